// File: doc/BRIEF.md
# Glitch-Free Synchronous Clock Stop Gate

This block sits between a clock generator's source clocks and its output pins. It turns two groups of derived clocks on and off without producing runt pulses: a group of host (CPU) clocks and a group of PCI clocks. A single free-running PCI clock is also passed through the block. Each group has an active-low stop pin. The request is first captured in the free-running PCI clock domain and then handed to each target clock, which applies it on its own falling edge. A stopped clock therefore always parks low, and its last high phase is always complete.

Each output also has an enable bit from the serial register bank. An output runs only when its enable bit is set and its group's stop pin allows it. Register disables act at once, without waiting for a clock edge. A mode input can take the stop pins out of service, for example when those pins are reused as clock outputs. The free-running PCI clock ignores the PCI stop pin and obeys only its own enable bit.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst_n` is low every gated output is low. After release, an output whose enable bit is set and whose stop pin allows it begins toggling.
- R2: An output that is stopped, by pin or by enable bit, stays at logic 0 for as long as the stop lasts. It never parks high.
- R3: A change on a stop pin is captured on a first rising edge of `free_pci_clk`, passed on at the second rising edge, and applied at the next falling edge of each affected source clock. With the pin changed 5 ns after a rising edge of a 20 ns free clock, a 10 ns CPU source rising 7 ns after that edge gives four more CPU pulses before it stops. On restart, the first CPU pulse rises 42 ns after the pin change.
- R4: `cpu_stop_n` low stops only `cpu_clk_out`. `pci_stop_n` low stops only `pci_clk_out`. `free_pci_out` keeps running in both cases.
- R5: Each output runs only when its enable bit is 1 and its group's stop pin is high. Either one at 0 stops it.
- R6: While `pin_ctrl_off` is 1, both stop pins are ignored and treated as high.
- R7: Clearing an enable bit forces that output low immediately, even in the middle of a high phase. Other outputs are not affected.
- R8: Stops and restarts requested through the pins never shorten a high phase: every high pulse of a pin-gated output equals a full high phase of its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| free_pci_clk | input | 1 | Free-running PCI source clock; also clocks the request capture |
| cpu_src_clk | input | N_CPU | CPU group source clocks |
| pci_src_clk | input | N_PCI | PCI group source clocks |
| cpu_stop_n | input | 1 | Active-low stop request for the CPU group |
| pci_stop_n | input | 1 | Active-low stop request for the PCI group (not the free clock) |
| pin_ctrl_off | input | 1 | 1 = stop pins unavailable, treated as high |
| cpu_clk_en | input | N_CPU | Per-output enable bits for CPU clocks |
| pci_clk_en | input | N_PCI | Per-output enable bits for PCI clocks |
| free_pci_en | input | 1 | Enable bit for the free-running PCI output |
| cpu_clk_out | output | N_CPU | Gated CPU clocks |
| pci_clk_out | output | N_PCI | Gated PCI clocks |
| free_pci_out | output | 1 | Gated free-running PCI clock |

## Verification
A capture register stuck in the run state would show up as CPU or PCI pulses counted in a window where the pin holds the group stopped. That window starts three free-clock cycles after the pin change. A wrong number of capture stages moves the last or first pulse by one free-clock period, so the exact pulse count after a stop and the time of the first pulse on restart would both be off. A per-output enable flop clocked on the wrong edge would show up at the first transition as a high pulse shorter than the source's high phase. A missing AND with the enable bit would leave a disabled output toggling within one source period.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // Index of each stop request inside the capture vector
  localparam int REQ_CPU = 0;
  localparam int REQ_PCI = 1;
  localparam int N_REQ   = 2;
endpackage

// File: rtl/stop_req_sync.sv
module stop_req_sync #(
  parameter int N_REQ = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pins_off,
  input  logic [N_REQ-1:0] stop_n,
  output logic [N_REQ-1:0] run
);
  logic [N_REQ-1:0] cap_q, cap_d;
  logic [N_REQ-1:0] run_q, run_d;

  // Next state: first stage samples the pins, second stage qualifies by mode
  always_comb begin
    cap_d = stop_n;
    run_d = pins_off ? {N_REQ{1'b1}} : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= {N_REQ{1'b1}};
      run_q <= {N_REQ{1'b1}};
    end else begin
      cap_q <= cap_d;
      run_q <= run_d;
    end
  end

  assign run = run_q;

  for (genvar g = 0; g < N_REQ; g++) begin : g_chk
    // R3
    run_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q[g]) |-> ($past(!stop_n[g], 2) && $past(!pins_off)));
    // R6
    pins_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pins_off) |-> run_q[g]);
  end
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic rst_n,
  input  logic clk_src,
  input  logic run_req,
  input  logic reg_en,
  output logic clk_out
);
  logic en_q, en_d;

  always_comb en_d = run_req;

  // Enable changes only while the source is low
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign clk_out = clk_src & en_q & reg_en;

  // R3
  en_fall_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
    $fell(en_q) |-> $past(!run_req));
  // R2
  park_low_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
    (!en_q || !reg_en) |-> !clk_out);
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_PCI = 6
) (
  input  logic             rst_n,
  input  logic             free_pci_clk,
  input  logic [N_CPU-1:0] cpu_src_clk,
  input  logic [N_PCI-1:0] pci_src_clk,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pin_ctrl_off,
  input  logic [N_CPU-1:0] cpu_clk_en,
  input  logic [N_PCI-1:0] pci_clk_en,
  input  logic             free_pci_en,
  output logic [N_CPU-1:0] cpu_clk_out,
  output logic [N_PCI-1:0] pci_clk_out,
  output logic             free_pci_out
);
  logic [N_REQ-1:0] stop_vec_n;
  logic [N_REQ-1:0] grp_run;

  always_comb begin
    stop_vec_n          = '1;
    stop_vec_n[REQ_CPU] = cpu_stop_n;
    stop_vec_n[REQ_PCI] = pci_stop_n;
  end

  stop_req_sync #(.N_REQ(N_REQ)) u_sync (
    .clk      (free_pci_clk),
    .rst_n    (rst_n),
    .pins_off (pin_ctrl_off),
    .stop_n   (stop_vec_n),
    .run      (grp_run)
  );

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    clk_gate_cell u_cell (
      .rst_n   (rst_n),
      .clk_src (cpu_src_clk[i]),
      .run_req (grp_run[REQ_CPU]),
      .reg_en  (cpu_clk_en[i]),
      .clk_out (cpu_clk_out[i])
    );
  end

  for (genvar j = 0; j < N_PCI; j++) begin : g_pci
    clk_gate_cell u_cell (
      .rst_n   (rst_n),
      .clk_src (pci_src_clk[j]),
      .run_req (grp_run[REQ_PCI]),
      .reg_en  (pci_clk_en[j]),
      .clk_out (pci_clk_out[j])
    );
  end

  // Free-running output: exempt from the pin request
  clk_gate_cell u_free (
    .rst_n   (rst_n),
    .clk_src (free_pci_clk),
    .run_req (1'b1),
    .reg_en  (free_pci_en),
    .clk_out (free_pci_out)
  );
endmodule

// File: tb/test_clkstop_gate.sv
`timescale 1ns/1ps
module test_clkstop_gate;
  localparam int N_CPU = 4;
  localparam int N_PCI = 6;

  logic rst_n, fclk, cpu_c, pci_c;
  logic cpu_stop_n, pci_stop_n, pin_ctrl_off, free_pci_en;
  logic [N_CPU-1:0] cpu_clk_en, cpu_clk_out;
  logic [N_PCI-1:0] pci_clk_en, pci_clk_out;
  logic free_pci_out;

  int errors = 0;
  int checks = 0;
  int cpu_cnt [N_CPU];
  int pci_cnt [N_PCI];
  int free_cnt = 0;
  int width_err = 0;
  int width_seen = 0;
  realtime cpu0_rise, pci0_rise, first_rise;
  logic [N_CPU-1:0] cpu_prev = '0;
  logic [N_PCI-1:0] pci_prev = '0;

  // 50 MHz free clock; CPU source 10 ns offset by 2 ns; PCI sources lag 3 ns
  initial begin fclk = 0; forever #10 fclk = ~fclk; end
  initial begin cpu_c = 0; #2; forever #5 cpu_c = ~cpu_c; end
  initial begin pci_c = 0; #3; forever #10 pci_c = ~pci_c; end

  clkstop_gate #(.N_CPU(N_CPU), .N_PCI(N_PCI)) i_clkstop_gate (
    .rst_n(rst_n), .free_pci_clk(fclk),
    .cpu_src_clk({N_CPU{cpu_c}}), .pci_src_clk({N_PCI{pci_c}}),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pin_ctrl_off(pin_ctrl_off),
    .cpu_clk_en(cpu_clk_en), .pci_clk_en(pci_clk_en), .free_pci_en(free_pci_en),
    .cpu_clk_out(cpu_clk_out), .pci_clk_out(pci_clk_out), .free_pci_out(free_pci_out)
  );

  always @(cpu_clk_out) begin
    for (int i = 0; i < N_CPU; i++)
      if (cpu_clk_out[i] && !cpu_prev[i]) cpu_cnt[i]++;
    if (cpu_clk_out[0] && !cpu_prev[0]) begin
      cpu0_rise = $realtime;
      if (first_rise < 0) first_rise = $realtime;
    end
    if (!cpu_clk_out[0] && cpu_prev[0]) begin
      width_seen++;
      if ($realtime - cpu0_rise > 5.01 || $realtime - cpu0_rise < 4.99) width_err++;
    end
    cpu_prev = cpu_clk_out;
  end

  always @(pci_clk_out) begin
    for (int i = 0; i < N_PCI; i++)
      if (pci_clk_out[i] && !pci_prev[i]) pci_cnt[i]++;
    if (pci_clk_out[0] && !pci_prev[0]) pci0_rise = $realtime;
    if (!pci_clk_out[0] && pci_prev[0]) begin
      width_seen++;
      if ($realtime - pci0_rise > 10.01 || $realtime - pci0_rise < 9.99) width_err++;
    end
    pci_prev = pci_clk_out;
  end

  always @(posedge free_pci_out) free_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < N_CPU; i++) cpu_cnt[i] = 0;
    for (int i = 0; i < N_PCI; i++) pci_cnt[i] = 0;
    free_cnt = 0;
  endtask

  // Leaves time at 5 ns after a rising edge of the free clock
  task automatic align();
    @(posedge fclk); #5;
  endtask

  task automatic window_counts(output int c0, output int p0, output int f);
    clear_counts(); #100;
    c0 = cpu_cnt[0]; p0 = pci_cnt[0]; f = free_cnt;
  endtask

  task automatic settle(); repeat (3) @(posedge fclk); align(); endtask

  task automatic t_reset();
    rst_n = 0; cpu_stop_n = 1; pci_stop_n = 1; pin_ctrl_off = 0;
    cpu_clk_en = '1; pci_clk_en = '1; free_pci_en = 1; first_rise = -1.0;
    for (int k = 0; k < 3; k++) begin
      #13;
      chk(cpu_clk_out == 0 && pci_clk_out == 0 && free_pci_out == 0, "R1 reset low",
          int'({cpu_clk_out, pci_clk_out, free_pci_out}), 0);
    end
    align(); rst_n = 1;
    settle();
    begin
      int c, p, f;
      window_counts(c, p, f);
      chk(c == 10, "R1 cpu runs after reset", c, 10);
      chk(p == 5 && f == 5, "R1 pci runs after reset", p * 10 + f, 55);
    end
  endtask

  task automatic t_cpu_stop();
    int c, p, f;
    align(); cpu_stop_n = 0;
    window_counts(c, p, f);
    chk(c == 4, "R3 cpu pulses after stop request", c, 4);
    window_counts(c, p, f);
    chk(c == 0 && cpu_cnt[3] == 0, "R4 cpu stopped", c, 0);
    chk(p == 5 && f == 5, "R4 pci unaffected by cpu stop", p * 10 + f, 55);
    chk(cpu_clk_out == 0, "R2 cpu parked low", int'(cpu_clk_out), 0);
    #7;
    chk(cpu_clk_out == 0, "R2 cpu parked low later", int'(cpu_clk_out), 0);
    align();
    first_rise = -1.0;
    begin
      realtime t0;
      t0 = $realtime;
      cpu_stop_n = 1;
      window_counts(c, p, f);
      chk(c == 6, "R3 cpu pulses after restart", c, 6);
      chk(first_rise > t0 + 41.99 && first_rise < t0 + 42.01, "R3 first restart rise",
          int'(first_rise - t0), 42);
    end
  endtask

  task automatic t_pci_stop();
    int c, p, f;
    align(); pci_stop_n = 0;
    window_counts(c, p, f);
    chk(p == 2, "R3 pci pulses after stop request", p, 2);
    window_counts(c, p, f);
    chk(p == 0 && pci_cnt[5] == 0, "R4 pci stopped", p, 0);
    chk(f == 5, "R4 free pci exempt from stop", f, 5);
    chk(c == 10, "R4 cpu unaffected by pci stop", c, 10);
    chk(pci_clk_out == 0, "R2 pci parked low", int'(pci_clk_out), 0);
    pci_stop_n = 1;
    settle();
    window_counts(c, p, f);
    chk(p == 5, "R3 pci resumes", p, 5);
  endtask

  task automatic t_mode();
    int c, p, f;
    align(); pin_ctrl_off = 1; cpu_stop_n = 0; pci_stop_n = 0;
    settle();
    window_counts(c, p, f);
    chk(c == 10 && p == 5 && f == 5, "R6 pins ignored when off", c * 100 + p * 10 + f, 1055);
    cpu_stop_n = 1; pci_stop_n = 1; pin_ctrl_off = 0;
    settle();
  endtask

  task automatic t_and();
    int c, p, f;
    cpu_clk_en[1] = 0; pci_clk_en[4] = 0;
    settle();
    window_counts(c, p, f);
    chk(cpu_cnt[1] == 0, "R5 cpu enable bit off", cpu_cnt[1], 0);
    chk(pci_cnt[4] == 0, "R5 pci enable bit off", pci_cnt[4], 0);
    chk(c == 10 && cpu_cnt[2] == 10 && p == 5, "R5 other outputs run", c, 10);
    free_pci_en = 0;
    window_counts(c, p, f);
    chk(f == 0, "R5 free pci enable bit off", f, 0);
    free_pci_en = 1; cpu_clk_en[1] = 1; pci_clk_en[4] = 1;
    settle();
  endtask

  task automatic t_async();
    @(posedge fclk); #8;   // CPU source high from +7 to +12
    chk(cpu_clk_out[2] == 1, "R7 cpu2 high before disable", int'(cpu_clk_out[2]), 1);
    cpu_clk_en[2] = 0;
    #0.5;
    chk(cpu_clk_out[2] == 0, "R7 immediate disable", int'(cpu_clk_out[2]), 0);
    chk(cpu_clk_out[3] == 1, "R7 neighbour unaffected", int'(cpu_clk_out[3]), 1);
    cpu_clk_en[2] = 1;
    settle();
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    width_err = 0; width_seen = 0;
    t_cpu_stop();
    t_pci_stop();
    t_mode();
    chk(width_err == 0, "R8 no shortened high phase", width_err, 0);
    chk(width_seen > 20, "R8 pulses observed", width_seen, 21);
    t_and();
    t_async();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule